// File: doc/BRIEF.md
# Serial Audio Stereo Receiver

This block takes a stereo stream of two's-complement samples carried on three wires (serial data, bit clock, word clock) and turns it into parallel samples in the system clock domain. Four framing styles are decoded: right-justified with the MSB first, right-justified with the LSB first, left-justified, and I2S. The word can be 16, 20 or 24 bits long. Two static pins select the framing and two select the word length. The bit clock may run at 48 or 64 cycles per word-clock period.

All three serial wires are brought into the system clock through two-flop synchronisers. Edges are then detected there, so the system clock must run several times faster than the bit clock. Each completed word is widened to a 24-bit left-aligned sample and tagged as left or right. It leaves on a valid/ready stream. Back-pressure rules: a presented sample stays on the outputs, unchanged, until the sink accepts it. A word that completes while a sample is still waiting is discarded. With ready held high, valid is a one-cycle strobe. A change on the configuration pins is reported with a one-cycle strobe. Framing then starts again cleanly.

Top module: `serial_audio_rx`

## Requirements
- R1: `fmt_sel` selects the framing: 2'b00 right-justified MSB first, 2'b01 right-justified LSB first, 2'b10 left-justified MSB first, 2'b11 I2S MSB first.
- R2: `wlen_sel` selects the word length: 2'b00 gives 16 bits, 2'b10 gives 20 bits, and both 2'b01 and 2'b11 give 24 bits.
- R3: Serial data is taken on rising bit-clock edges, and framing works with either 24 or 32 bit-clock cycles per word-clock half period.
- R4: In left-justified mode the word starts at the first rising edge after a word-clock change. In I2S mode it starts one bit-clock cycle later. In both modes, bits after the word's LSB are ignored.
- R5: In the right-justified modes the last bit of the word is the one sampled on the final rising bit-clock edge before the word-clock change.
- R6: `smp_right` is 0 for the left channel. The left channel is word clock low in I2S mode and word clock high in the other three modes.
- R7: `smp_data` carries the word left-aligned in 24 bits with zeros below its LSB. An LSB-first word is bit-reversed before alignment, so `smp_data` always holds the MSB in bit 23.
- R8: `smp_valid` stays high with `smp_data` and `smp_right` unchanged until `smp_ready` is seen high. A word that completes while a sample is waiting is dropped. With `smp_ready` high, `smp_valid` lasts one cycle.
- R9: A change on `fmt_sel` or `wlen_sel` gives a one-cycle `cfg_changed` pulse in the cycle after it is seen. The word in progress is discarded, and output resumes with the first word that starts at or after the next word-clock change.
- R10: After reset `smp_valid`, `smp_data` and `cfg_changed` are zero. The partial word in progress when reset is released is not delivered.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sd_in | input | 1 | Serial audio data |
| sck_in | input | 1 | Serial bit clock |
| ws_in | input | 1 | Word (channel) clock |
| fmt_sel | input | 2 | Framing select (R1) |
| wlen_sel | input | 2 | Word length select (R2) |
| smp_valid | output | 1 | Sample available |
| smp_ready | input | 1 | Sink accepts the sample |
| smp_data | output | 24 | Left-aligned sample |
| smp_right | output | 1 | Channel tag, 1 = right |
| cfg_changed | output | 1 | One-cycle pulse on a configuration change |

## Verification
The stimulus table walks every framing, all four word-length codes including the two redundant 24-bit codes, and both 48 and 64 bit clocks per word. It fills the slack bits with toggling junk. A design that misplaced the I2S delay, kept trailing left-justified bits, or forgot the LSB-first reversal would deliver shifted or mirrored samples. A design that confused channel polarity would swap the tags in only some modes. A directed test changes the word length in the middle of a word. A design that failed to discard that word would deliver an extra sample built from mixed framing. Another directed test stalls the sink across two completed words. A design that overwrote the waiting sample, or delivered both, would show the wrong value or the wrong count.

// File: rtl/serial_audio_rx_pkg.sv
package serial_audio_rx_pkg;

  typedef enum logic [1:0] {
    FMT_RJ_MSB = 2'b00,
    FMT_RJ_LSB = 2'b01,
    FMT_LJ     = 2'b10,
    FMT_I2S    = 2'b11
  } frame_fmt_e;

  typedef struct packed {
    frame_fmt_e  fmt;
    logic [1:0]  wlen;
  } rx_cfg_t;

  // Two codes map onto the widest word
  function automatic int unsigned word_bits(input logic [1:0] wl);
    case (wl)
      2'b00:   return 16;
      2'b10:   return 20;
      default: return 24;
    endcase
  endfunction

endpackage

// File: rtl/serial_audio_rx_sync.sv
module serial_audio_rx_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/serial_audio_rx_align.sv
module serial_audio_rx_align
  import serial_audio_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24
) (
  input  logic [SAMPLE_W-1:0] shreg,
  input  rx_cfg_t             cfg,
  output logic [SAMPLE_W-1:0] aligned
);

  localparam int NB_W = $clog2(SAMPLE_W + 1);

  logic [NB_W-1:0]     nbits;
  logic [SAMPLE_W-1:0] raw;
  logic [SAMPLE_W-1:0] rev;
  logic                lsb_first;

  assign nbits     = NB_W'(word_bits(cfg.wlen));
  assign lsb_first = (cfg.fmt == FMT_RJ_LSB);

  // Oldest received bit (LSB in LSB-first order) sits highest in the register
  always_comb begin
    rev = '0;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (i < int'(nbits)) rev[i] = shreg[int'(nbits) - 1 - i];
    end
  end

  always_comb begin
    raw = '0;
    for (int i = 0; i < SAMPLE_W; i++) begin
      if (i < int'(nbits)) raw[i] = lsb_first ? rev[i] : shreg[i];
    end
    aligned = raw << (SAMPLE_W - int'(nbits));
  end

endmodule

// File: rtl/serial_audio_rx_framer.sv
module serial_audio_rx_framer
  import serial_audio_rx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int POS_W    = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sck_s,
  input  logic                ws_s,
  input  logic                sd_s,
  input  rx_cfg_t             cfg,
  input  logic                restart,
  output logic                word_stb,
  output logic [SAMPLE_W-1:0] word_data,
  output logic                word_right
);

  localparam logic [POS_W-1:0] POS_MAX = '1;

  logic                sck_d;
  logic                ws_q;
  logic                armed;
  logic [POS_W-1:0]    pos_q;
  logic [SAMPLE_W-1:0] shreg;

  logic                sck_rise;
  logic                ws_edge;
  logic [POS_W-1:0]    pos_cur;
  logic [POS_W-1:0]    nb;
  logic                cap;
  logic                left_now;
  logic [SAMPLE_W-1:0] aligned;

  assign sck_rise = sck_s & ~sck_d;
  assign ws_edge  = ws_s ^ ws_q;
  assign pos_cur  = ws_edge ? '0 : pos_q;
  assign nb       = POS_W'(word_bits(cfg.wlen));

  // Which bit positions inside a half period are part of the word
  always_comb begin
    case (cfg.fmt)
      FMT_LJ:  cap = (pos_cur < nb);
      FMT_I2S: cap = (pos_cur >= POS_W'(1)) && (pos_cur <= nb);
      default: cap = 1'b1;
    endcase
  end

  // Channel of the word that is ending, from the level it was framed under
  assign left_now = (cfg.fmt == FMT_I2S) ? ~ws_q : ws_q;

  serial_audio_rx_align #(.SAMPLE_W(SAMPLE_W)) u_align (
    .shreg   (shreg),
    .cfg     (cfg),
    .aligned (aligned)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_d      <= 1'b0;
      ws_q       <= 1'b0;
      armed      <= 1'b0;
      pos_q      <= '0;
      shreg      <= '0;
      word_stb   <= 1'b0;
      word_data  <= '0;
      word_right <= 1'b0;
    end else begin
      sck_d    <= sck_s;
      word_stb <= 1'b0;
      if (restart) armed <= 1'b0;
      if (sck_rise) begin
        ws_q <= ws_s;
        if (ws_edge && !restart) begin
          if (armed) begin
            word_stb   <= 1'b1;
            word_data  <= aligned;
            word_right <= ~left_now;
          end
          armed <= 1'b1;
        end
        if (cap) shreg <= {shreg[SAMPLE_W-2:0], sd_s};
        pos_q <= (pos_cur == POS_MAX) ? pos_cur : pos_cur + POS_W'(1);
      end
    end
  end

endmodule

// File: rtl/serial_audio_rx_outq.sv
module serial_audio_rx_outq #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_stb,
  input  logic [SAMPLE_W-1:0] in_data,
  input  logic                in_right,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [SAMPLE_W-1:0] out_data,
  output logic                out_right
);

  logic take;

  assign take = in_stb && (!out_valid || out_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_right <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
      out_right <= in_right;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import serial_audio_rx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SYNC_DEPTH = 2,
  parameter int POS_W     = 7
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sd_in,
  input  logic                sck_in,
  input  logic                ws_in,
  input  logic [1:0]          fmt_sel,
  input  logic [1:0]          wlen_sel,
  output logic                smp_valid,
  input  logic                smp_ready,
  output logic [SAMPLE_W-1:0] smp_data,
  output logic                smp_right,
  output logic                cfg_changed
);

  logic [2:0]          wires_s;
  rx_cfg_t             cfg_pins;
  rx_cfg_t             cfg_q;
  logic                cfg_live;
  logic                restart;
  logic                word_stb;
  logic [SAMPLE_W-1:0] word_data;
  logic                word_right;

  serial_audio_rx_sync #(.W(3), .STAGES(SYNC_DEPTH)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   ({sck_in, ws_in, sd_in}),
    .dout  (wires_s)
  );

  assign cfg_pins = '{fmt: frame_fmt_e'(fmt_sel), wlen: wlen_sel};
  assign restart  = cfg_live && (cfg_pins != cfg_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q       <= '{fmt: FMT_RJ_MSB, wlen: 2'b00};
      cfg_live    <= 1'b0;
      cfg_changed <= 1'b0;
    end else begin
      cfg_q       <= cfg_pins;
      cfg_live    <= 1'b1;
      cfg_changed <= restart;
    end
  end

  serial_audio_rx_framer #(.SAMPLE_W(SAMPLE_W), .POS_W(POS_W)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .sck_s      (wires_s[2]),
    .ws_s       (wires_s[1]),
    .sd_s       (wires_s[0]),
    .cfg        (cfg_q),
    .restart    (restart),
    .word_stb   (word_stb),
    .word_data  (word_data),
    .word_right (word_right)
  );

  serial_audio_rx_outq #(.SAMPLE_W(SAMPLE_W)) u_outq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_stb    (word_stb),
    .in_data   (word_data),
    .in_right  (word_right),
    .out_valid (smp_valid),
    .out_ready (smp_ready),
    .out_data  (smp_data),
    .out_right (smp_right)
  );

endmodule

// File: rtl/serial_audio_rx_checks.sv
module serial_audio_rx_checks #(
  parameter int SAMPLE_W = 24
) (
  input logic                clk,
  input logic                rst_n,
  input logic [1:0]          fmt_sel,
  input logic [1:0]          wlen_sel,
  input logic                smp_valid,
  input logic                smp_ready,
  input logic [SAMPLE_W-1:0] smp_data,
  input logic                smp_right,
  input logic                cfg_changed
);

  // R8: a stalled sample is held unchanged
  p_hold_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && !smp_ready |=> smp_valid && $stable(smp_data) && $stable(smp_right));

  // R8: with the sink ready, valid is a single-cycle strobe
  p_single_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid && smp_ready |=> !smp_valid);

  // R9: every pin change is reported on the next cycle
  p_cfg_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ({fmt_sel, wlen_sel} != $past({fmt_sel, wlen_sel})) |=> cfg_changed);

  // R7: zero fill below a 16-bit word
  p_fill16_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid) && (wlen_sel == 2'b00) |-> (smp_data[SAMPLE_W-17:0] == '0));

  // R7: zero fill below a 20-bit word
  p_fill20_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(smp_valid) && (wlen_sel == 2'b10) |-> (smp_data[SAMPLE_W-21:0] == '0));

endmodule

bind serial_audio_rx serial_audio_rx_checks #(.SAMPLE_W(SAMPLE_W)) u_checks (
  .clk         (clk),
  .rst_n       (rst_n),
  .fmt_sel     (fmt_sel),
  .wlen_sel    (wlen_sel),
  .smp_valid   (smp_valid),
  .smp_ready   (smp_ready),
  .smp_data    (smp_data),
  .smp_right   (smp_right),
  .cfg_changed (cfg_changed)
);

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;

  typedef struct packed {
    logic [1:0]  fmt;
    logic [1:0]  wl;
    logic [6:0]  k;
    logic [23:0] a;
    logic [23:0] b;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 2'b00, 7'd24, 24'h1234A5, 24'h00F00F},
    '{2'b01, 2'b00, 7'd32, 24'h00C3E1, 24'h008001},
    '{2'b10, 2'b10, 7'd32, 24'h0ABCDE, 24'h080003},
    '{2'b11, 2'b01, 7'd32, 24'h800001, 24'h5A5A5A},
    '{2'b00, 2'b11, 7'd32, 24'hFEDCBA, 24'h013579},
    '{2'b01, 2'b10, 7'd24, 24'h0F0F0F, 24'h0C0001},
    '{2'b10, 2'b11, 7'd32, 24'h9ABCDE, 24'h7FFFFE},
    '{2'b11, 2'b00, 7'd24, 24'h00BEEF, 24'h008421},
    '{2'b10, 2'b00, 7'd24, 24'h00FACE, 24'h000137},
    '{2'b00, 2'b10, 7'd32, 24'h0DCBA9, 24'h0ABCDE}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sd_in = 1'b0;
  logic        sck_in = 1'b0;
  logic        ws_in = 1'b0;
  logic [1:0]  fmt_sel = 2'b00;
  logic [1:0]  wlen_sel = 2'b00;
  logic        smp_ready = 1'b1;
  logic        smp_valid;
  logic [23:0] smp_data;
  logic        smp_right;
  logic        cfg_changed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [23:0] exp_d [64];
  logic        exp_r [64];
  int          exp_n = 0;
  logic [23:0] got_d [64];
  logic        got_r [64];
  int          got_n = 0;
  int          cfg_exp = 0;
  int          cfg_seen = 0;

  logic        ws_lvl = 1'b0;
  bit          have_prev = 1'b0;
  logic [23:0] prev_d;
  logic        prev_r;

  always #2.5 clk = ~clk;

  serial_audio_rx uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sd_in       (sd_in),
    .sck_in      (sck_in),
    .ws_in       (ws_in),
    .fmt_sel     (fmt_sel),
    .wlen_sel    (wlen_sel),
    .smp_valid   (smp_valid),
    .smp_ready   (smp_ready),
    .smp_data    (smp_data),
    .smp_right   (smp_right),
    .cfg_changed (cfg_changed)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (smp_valid && smp_ready && got_n < 64) begin
        got_d[got_n] = smp_data;
        got_r[got_n] = smp_right;
        got_n++;
      end
      if (cfg_changed) cfg_seen++;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic int nbits(input logic [1:0] wl);
    if (wl == 2'b00) return 16;
    if (wl == 2'b10) return 20;
    return 24;
  endfunction

  // Serial bit at position pos of a half period of k bits (R1, R4, R5)
  function automatic logic bit_at(input logic [1:0] f, input int n, input logic [23:0] v,
                                  input int pos, input int k);
    int idx;
    idx = pos - (k - n);
    case (f)
      2'b00:   return (idx >= 0) ? v[n-1-idx] : pos[0];
      2'b01:   return (idx >= 0) ? v[idx] : pos[0];
      2'b10:   return (pos < n) ? v[n-1-pos] : ~pos[0];
      default: return (pos >= 1 && pos <= n) ? v[n-pos] : pos[0];
    endcase
  endfunction

  task automatic push_exp(input logic [23:0] d, input logic r);
    exp_d[exp_n] = d;
    exp_r[exp_n] = r;
    exp_n++;
  endtask

  task automatic set_cfg(input logic [1:0] f, input logic [1:0] wl);
    if (f != fmt_sel || wl != wlen_sel) begin
      fmt_sel   = f;
      wlen_sel  = wl;
      cfg_exp++;
      have_prev = 1'b0;
    end
    #30;
  endtask

  task automatic send_half(input logic [23:0] v, input int k, input bit push_ok,
                           input int chg_pos, input logic [1:0] chg_wl);
    logic [1:0] f;
    int n;
    f = fmt_sel;
    n = nbits(wlen_sel);
    ws_lvl = ~ws_lvl;
    if (have_prev && push_ok) push_exp(prev_d, prev_r);
    for (int pos = 0; pos < k; pos++) begin
      sd_in = bit_at(f, n, v, pos, k);
      if (pos == 0) ws_in = ws_lvl;
      if (pos == chg_pos) begin
        wlen_sel = chg_wl;
        cfg_exp++;
      end
      #20 sck_in = 1'b1;
      #20 sck_in = 1'b0;
    end
    prev_d    = 24'(v << (24 - n));
    prev_r    = (f == 2'b11) ? ws_lvl : ~ws_lvl;
    have_prev = (chg_pos < 0);
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R10 watchdog expired actual=%0d expected=%0d", got_n, exp_n);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    fmt_sel  = VECS[0].fmt;
    wlen_sel = VECS[0].wl;
    #52 rst_n = 1'b1;
    #21;
    // R10: reset state
    chk(smp_valid == 1'b0, "R10 valid after reset", 32'(smp_valid), 32'h0);
    chk(smp_data == 24'h0, "R10 data after reset", 32'(smp_data), 32'h0);
    chk(cfg_changed == 1'b0, "R10 cfg_changed after reset", 32'(cfg_changed), 32'h0);

    // Table walk: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      set_cfg(VECS[i].fmt, VECS[i].wl);
      send_half(VECS[i].a, int'(VECS[i].k), 1'b1, -1, 2'b00);
      send_half(VECS[i].b, int'(VECS[i].k), 1'b1, -1, 2'b00);
      send_half(VECS[i].a ^ VECS[i].b, int'(VECS[i].k), 1'b1, -1, 2'b00);
    end

    // R9: word length changes in the middle of a word; that word is dropped
    send_half(24'h0AAAAA, 32, 1'b1, 10, 2'b00);
    send_half(24'h00C0DE, 32, 1'b1, -1, 2'b00);
    send_half(24'h001111, 32, 1'b1, -1, 2'b00);

    // R8: stall across two completed words
    set_cfg(2'b10, 2'b01);
    smp_ready = 1'b0;
    send_half(24'h3C3C3C, 32, 1'b1, -1, 2'b00);
    send_half(24'hC3C3C3, 32, 1'b1, -1, 2'b00);
    send_half(24'h777777, 32, 1'b0, -1, 2'b00);
    #100;
    chk(smp_valid == 1'b1, "R8 valid held while stalled", 32'(smp_valid), 32'h1);
    chk(smp_data == exp_d[exp_n-1], "R8 first word kept while stalled",
        32'(smp_data), 32'(exp_d[exp_n-1]));
    smp_ready = 1'b1;
    #50;
    chk(smp_valid == 1'b0, "R8 valid drops after accept", 32'(smp_valid), 32'h0);

    // Stream contents
    chk(got_n == exp_n, "R10 R8 R9 sample count", 32'(got_n), 32'(exp_n));
    for (int i = 0; i < exp_n && i < got_n; i++) begin
      chk(got_d[i] == exp_d[i], $sformatf("R1 R2 R3 R4 R5 R7 sample %0d", i),
          32'(got_d[i]), 32'(exp_d[i]));
      chk(got_r[i] == exp_r[i], $sformatf("R6 channel tag %0d", i),
          32'(got_r[i]), 32'(exp_r[i]));
    end
    chk(cfg_seen == cfg_exp, "R9 cfg_changed pulses", 32'(cfg_seen), 32'(cfg_exp));

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule